// File: doc/BRIEF.md
# DAC Code Gain and Offset Trim Stage

This block is a synchronous correction stage that sits between the register side of a 16-bit converter and its core. It takes each raw input code, multiplies it by a programmable gain and adds a programmable signed offset. The result is clamped to the unsigned code range and passed to the converter core as a corrected code, together with a one-cycle valid strobe.

Software writes the gain, the offset and the data word through one write port that carries an address. Gain and offset writes only load holding registers and never move the output. A data write computes the corrected code from the data word and the gain and offset values held at that moment. This lets a calibration change to both gain and offset take effect as a single step, on the next data word.

Top module: `dac_trim_stage`

## Requirements
- R1: After reset `codeOut` is 0x0000 and `codeValid` is low. The held gain is 0x8000 and the held offset is 0x0000, so a data write with no calibration writes before it outputs the data word unchanged.
- R2: The gain code is unsigned and gives a factor of 0.5 + code/65536. The product is computed as data × (code + 32768) and shifted right by 16.
- R3: The fractional bits of the scaled value are dropped by truncation, not rounding. For example, data 1 at gain code 0x0000 gives 0, and data 3 at gain code 0x0000 gives 1.
- R4: The offset code is 16-bit two's complement, with bit 15 weighted −32768, and it is added after the gain. For example, 0xFFFE adds −2 and 0x7FFF adds +32767.
- R5: A sum below zero is output as 0x0000.
- R6: A sum above 65535 is output as 0xFFFF.
- R7: A gain or offset write leaves `codeOut` unchanged and does not raise `codeValid`.
- R8: The corrected code appears on `codeOut` on the clock edge that accepts the data write. `codeValid` is high for exactly the one cycle after each data write.
- R9: A gain write and an offset write made before a data write are both applied to that data word. The held values stay in force for all later data writes until they are rewritten.
- R10: `wrAddr` selects the target of a write: 0 is gain, 1 is offset, 2 is data. A write to address 3 changes neither the output nor the held gain and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | 2 | Write target: 0 gain, 1 offset, 2 data, 3 unused |
| wrData | input | 16 | Write value |
| codeOut | output | 16 | Corrected code to the converter core |
| codeValid | output | 1 | High for one cycle after each data write |

## Verification
The bench targets the following corner cases:
- Gain code 0x0000 with small odd data words. A design that rounds instead of truncating returns a result one above the expected value here.
- Offsets 0x8000 and 0x7FFF at both ends of the data and gain range. A design that zero-extends the offset, or that wraps instead of clamping, returns values far from 0x0000 or 0xFFFF.
- Calibration writes with no data write after them. These expose a design that recomputes the output when gain or offset changes.
- Writes to the unused address, and data writes that reuse earlier calibration values. These show whether the held values are lost or overwritten.
- A random mix of writes with a fixed seed, checked against a bench model that uses wide integers.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;

  typedef enum logic [1:0] {
    ADDR_GAIN   = 2'd0,
    ADDR_OFFSET = 2'd1,
    ADDR_DATA   = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic loadGain;
    logic loadOffset;
    logic commit;
  } trimStrobes_t;

endpackage

// File: rtl/dac_trim_ctrl.sv
module dac_trim_ctrl
  import dac_trim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  output trimStrobes_t strobes,
  output logic         codeValid
);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (regAddr_t'(wrAddr))
        ADDR_GAIN:   strobes.loadGain   = 1'b1;
        ADDR_OFFSET: strobes.loadOffset = 1'b1;
        ADDR_DATA:   strobes.commit     = 1'b1;
        default:     strobes            = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeValid <= 1'b0;
    else       codeValid <= strobes.commit;
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadGain, strobes.loadOffset, strobes.commit}));

  // R8
  valid_follows_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> codeValid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> !codeValid);

endmodule

// File: rtl/dac_trim_dp.sv
module dac_trim_dp
  import dac_trim_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  trimStrobes_t      strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] codeOut
);

  localparam int FACT_W  = WORD_W + 1;
  localparam int PROD_W  = WORD_W + FACT_W;
  localparam int SCALE_W = WORD_W + 1;
  localparam int SUM_W   = WORD_W + 2;
  localparam logic [FACT_W-1:0] HALF = FACT_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] UNITY = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] CODE_MAX = '1;

  logic [WORD_W-1:0] gainHeld;
  logic [WORD_W-1:0] offsetHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainHeld   <= UNITY;
      offsetHeld <= '0;
    end else begin
      if (strobes.loadGain)   gainHeld   <= wrData;
      if (strobes.loadOffset) offsetHeld <= wrData;
    end
  end

  logic [FACT_W-1:0]        gainFactor;
  logic [PROD_W-1:0]        product;
  logic [SCALE_W-1:0]       scaled;
  logic signed [SUM_W-1:0]  scaledExt;
  logic signed [SUM_W-1:0]  offsetExt;
  logic signed [SUM_W-1:0]  sum;
  logic [WORD_W-1:0]        clamped;

  always_comb begin
    gainFactor = {1'b0, gainHeld} + HALF;
    product    = PROD_W'(wrData) * PROD_W'(gainFactor);
    scaled     = product[WORD_W +: SCALE_W];
    scaledExt  = {1'b0, scaled};
    offsetExt  = {{(SUM_W - WORD_W){offsetHeld[WORD_W-1]}}, offsetHeld};
    sum        = scaledExt + offsetExt;
    if (sum[SUM_W-1])                  clamped = '0;
    else if (|sum[SUM_W-2:WORD_W])     clamped = CODE_MAX;
    else                               clamped = sum[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               codeOut <= '0;
    else if (strobes.commit) codeOut <= clamped;
  end

  // R7
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(codeOut));

  // R1
  unity_passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && gainHeld == UNITY && offsetHeld == '0)
      |=> codeOut == $past(wrData));

  // R5
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && wrData == '0 && offsetHeld[WORD_W-1]) |=> codeOut == '0);

  // R6
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && wrData == CODE_MAX && gainHeld == CODE_MAX
      && !offsetHeld[WORD_W-1]) |=> codeOut == CODE_MAX);

endmodule

// File: rtl/dac_trim_stage.sv
module dac_trim_stage
  import dac_trim_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] codeOut,
  output logic              codeValid
);

  trimStrobes_t strobes;

  dac_trim_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .strobes   (strobes),
    .codeValid (codeValid)
  );

  dac_trim_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .codeOut (codeOut)
  );

endmodule

// File: tb/dac_trim_stage_bench.sv
module dac_trim_stage_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] codeOut;
  logic        codeValid;

  int passed = 0;
  int total  = 0;
  bit done   = 1'b0;

  logic [15:0] mGain   = 16'h8000;
  logic [15:0] mOffset = 16'h0000;
  logic [15:0] lastOut = 16'h0000;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dac_trim_stage u_dac_trim_stage (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .codeOut   (codeOut),
    .codeValid (codeValid)
  );

  function automatic logic [15:0] model(input logic [15:0] d, input logic [15:0] g,
                                        input logic [15:0] o);
    longint p;
    longint s;
    p = longint'(d) * (longint'(g) + 64'sd32768);
    s = (p >>> 16) + longint'($signed(o));
    if (s < 0) return 16'h0000;
    if (s > 65535) return 16'hFFFF;
    return s[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic calWrite(input logic [1:0] a, input logic [15:0] d, input string tag);
    doWrite(a, d);
    if (a == 2'd0) mGain = d;
    if (a == 2'd1) mOffset = d;
    check(codeOut == lastOut, tag, codeOut, lastOut);
    check(codeValid == 1'b0, tag, 16'(codeValid), 16'h0);
  endtask

  task automatic dataWrite(input logic [15:0] d, input string tag);
    logic [15:0] e;
    e = model(d, mGain, mOffset);
    doWrite(2'd2, d);
    lastOut = e;
    check(codeOut == e, tag, codeOut, e);
    check(codeValid == 1'b1, tag, 16'(codeValid), 16'h1);
  endtask

  function automatic logic [15:0] pickValue();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(codeOut == 16'h0000, "R1", codeOut, 16'h0000);
    check(codeValid == 1'b0, "R1", 16'(codeValid), 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    dataWrite(16'h1234, "R1");
    // R8 valid lasts one cycle
    @(negedge clk);
    check(codeValid == 1'b0, "R8", 16'(codeValid), 16'h0);
    check(codeOut == 16'h1234, "R8", codeOut, 16'h1234);
    // R3 truncation at gain 0.5
    calWrite(2'd0, 16'h0000, "R7");
    dataWrite(16'h0001, "R3");
    dataWrite(16'h0003, "R3");
    // R2 gain mapping
    calWrite(2'd0, 16'hFFFF, "R7");
    dataWrite(16'h4000, "R2");
    calWrite(2'd0, 16'h4000, "R7");
    dataWrite(16'hABCD, "R2");
    // R4 negative and positive offset after gain
    calWrite(2'd0, 16'h8000, "R7");
    calWrite(2'd1, 16'hFFFE, "R7");
    dataWrite(16'd10, "R4");
    check(codeOut == 16'd8, "R4", codeOut, 16'd8);
    calWrite(2'd1, 16'h7FFF, "R7");
    dataWrite(16'h0001, "R4");
    // R5 low clamp
    calWrite(2'd1, 16'h8000, "R7");
    dataWrite(16'h0100, "R5");
    check(codeOut == 16'h0000, "R5", codeOut, 16'h0000);
    // R6 high clamp
    calWrite(2'd0, 16'hFFFF, "R7");
    calWrite(2'd1, 16'h7FFF, "R7");
    dataWrite(16'hFFFF, "R6");
    check(codeOut == 16'hFFFF, "R6", codeOut, 16'hFFFF);
    // R9 both applied together, then retained
    calWrite(2'd0, 16'hC000, "R9");
    calWrite(2'd1, 16'h0010, "R9");
    dataWrite(16'h2000, "R9");
    dataWrite(16'h3000, "R9");
    // R10 spare address has no effect
    calWrite(2'd3, 16'h0000, "R10");
    dataWrite(16'h1111, "R10");
    // R8 back-to-back data writes
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'h0500;
    @(negedge clk);
    lastOut = model(16'h0500, mGain, mOffset);
    check(codeOut == lastOut && codeValid, "R8", codeOut, lastOut);
    wrData = 16'h0600;
    @(negedge clk);
    wrEn = 1'b0;
    lastOut = model(16'h0600, mGain, mOffset);
    check(codeOut == lastOut && codeValid, "R8", codeOut, lastOut);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      a = 2'($urandom % 4);
      if (a == 2'd2) dataWrite(pickValue(), "R2");
      else calWrite(a, pickValue(), "R10");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule